// File: doc/BRIEF.md
# Dual-Issue Instruction Dispatch Unit

This unit sits between a fetch buffer and two five-stage execution pipes, named F and M. Each cycle the fetch buffer offers up to two decoded instructions in program order: an older one in slot 0 and a younger one in slot 1. Each instruction carries a class code, a steering bit that names its pipe, a destination register, two source registers and a tag. The unit decides whether both instructions issue, whether only the older one issues, or whether nothing issues. An instruction that issues enters the I stage of the pipe it is steered to.

Both pipes advance in lock step through the logical stages I, R, A, D and W. State is committed only in W. The F pipe may be physically deeper than five stages in its execution path, but the unit tracks only the five logical stages, so the commit point it reports does not move. A taken branch resolved in stage A squashes the younger work in stages I and R of both pipes and requests a fetch redirect. A stall from the downstream stages freezes every stage.

Each slot is a valid/ready pair. `cN_valid` must not depend on `cN_ready`. A slot transfers on a cycle where both are high. `c0_ready` may be high only while `c0_valid` is high. `c1_ready` is never high without `c0_ready`. When slot 0 transfers alone, the buffer must present the old slot-1 instruction as the new slot 0 in the next cycle. When nothing transfers, both slots keep their contents.

Top module: `dual_dispatch`

## Requirements
- R1: Two candidates with the same steering bit (0 = F pipe, 1 = M pipe) never transfer together. The older one transfers alone and `c1_ready` stays low.
- R2: Issue is in program order. `c1_ready` is high only when `c0_ready` is high. `c0_ready` equals `c0_valid` whenever there is no stall and no honoured branch.
- R3: An instruction that transfers appears valid, with its tag, in stage I (index 0) of its pipe after the next clock edge. On every cycle without a stall, each stage's valid bit and tag move one stage on (I=0, R=1, A=2, D=3, W=4), and an entry in W leaves the pipe.
- R4: The younger candidate does not transfer in the same cycle as the older one if it reads the older one's destination register (through either source) or writes the same destination register.
- R5: While `stall` is high, both ready outputs are low, and every stage valid bit and tag of both pipes holds its value.
- R6: A branch is honoured when `br_taken` is high, `stall` is low, and stage A of either pipe holds a valid instruction of class 3 (the branch class). The class codes are 0 integer, 1 load/store, 2 floating-point and 3 branch. In a cycle with an honoured branch, nothing transfers, stages I and R of both pipes become invalid, and A, D and W advance normally.
- R7: `redirect` is high for exactly the one cycle that follows an honoured branch, and low otherwise.
- R8: `br_taken` has no effect when neither stage A holds a valid branch-class instruction.
- R9: After reset, every stage valid bit is 0 and `redirect` is 0.
- R10: A destination register of 0 means no write. It never blocks pairing through R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Freeze request from the downstream stages |
| br_taken | input | 1 | The branch now in stage A resolved taken |
| c0_valid | input | 1 | Older candidate present |
| c0_ready | output | 1 | Older candidate transfers this cycle |
| c0_cls | input | 2 | Older candidate's class code |
| c0_pipe | input | 1 | Older candidate's steering bit, 0 = F, 1 = M |
| c0_dst | input | REG_W | Older candidate's destination register |
| c0_tag | input | TAG_W | Older candidate's tag |
| c1_valid | input | 1 | Younger candidate present |
| c1_ready | output | 1 | Younger candidate transfers this cycle |
| c1_cls | input | 2 | Younger candidate's class code |
| c1_pipe | input | 1 | Younger candidate's steering bit |
| c1_dst | input | REG_W | Younger candidate's destination register |
| c1_src_a | input | REG_W | Younger candidate's first source register |
| c1_src_b | input | REG_W | Younger candidate's second source register |
| c1_tag | input | TAG_W | Younger candidate's tag |
| stg_valid_f | output | NSTG | F-pipe stage valid bits, bit 0 = I |
| stg_tag_f | output | NSTG*TAG_W | F-pipe stage tags, stage k at bits k*TAG_W upward |
| stg_valid_m | output | NSTG | M-pipe stage valid bits |
| stg_tag_m | output | NSTG*TAG_W | M-pipe stage tags |
| redirect | output | 1 | Fetch redirect, one cycle after an honoured branch |

## Verification
The bound checker tests on every cycle the rules that can be stated at the ports:
- no same-pipe pair, and the younger slot never transfers without the older one;
- no pairing across a register conflict;
- the stall freeze;
- the lock-step shift of D and W;
- the empty I, R and A stages when `redirect` is high;
- the one-cycle width of `redirect`.

Other behaviours can only be shown by the bench's scenarios compared against its own model of both pipes, stage by stage:
- that tags land in the right pipe and stage;
- that a dangling `br_taken` is ignored;
- that a slot-1 instruction left behind moves up to slot 0 and issues later in order.

// File: rtl/dd_pkg.sv
package dd_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_LS  = 2'd1,
    CLS_FP  = 2'd2,
    CLS_BR  = 2'd3
  } cls_e;

  localparam logic PIPE_F = 1'b0;
  localparam logic PIPE_M = 1'b1;
  localparam int   NPIPE  = 2;
  localparam int   ST_I   = 0;
  localparam int   ST_R   = 1;
  localparam int   ST_A   = 2;
endpackage

// File: rtl/dd_pair_rule.sv
module dd_pair_rule #(
  parameter int REG_W = 5
) (
  input  logic             stall,
  input  logic             flush,
  input  logic             c0_valid,
  input  logic             c0_pipe,
  input  logic [REG_W-1:0] c0_dst,
  input  logic             c1_valid,
  input  logic             c1_pipe,
  input  logic [REG_W-1:0] c1_dst,
  input  logic [REG_W-1:0] c1_src_a,
  input  logic [REG_W-1:0] c1_src_b,
  output logic             take0,
  output logic             take1
);
  logic old_writes;
  logic same_pipe;
  logic raw_hit;
  logic waw_hit;

  always_comb begin
    old_writes = (c0_dst != '0);
    same_pipe  = (c0_pipe == c1_pipe);
    raw_hit    = old_writes && ((c1_src_a == c0_dst) || (c1_src_b == c0_dst));
    waw_hit    = old_writes && (c1_dst == c0_dst);
    take0      = c0_valid && !stall && !flush;
    take1      = take0 && c1_valid && !same_pipe && !raw_hit && !waw_hit;
  end
endmodule

// File: rtl/dd_pipe_track.sv
module dd_pipe_track #(
  parameter int TAG_W = 8,
  parameter int NSTG  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              squash,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic              ins_br,
  output logic [NSTG-1:0]   stg_valid,
  output logic [NSTG*TAG_W-1:0] stg_tag,
  output logic              a_branch
);
  import dd_pkg::*;

  logic [NSTG-1:0] vld_q;
  logic [NSTG-1:0] br_q;
  logic [TAG_W-1:0] tag_q [NSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= 1'b0;
      br_q[0]  <= 1'b0;
      tag_q[0] <= '0;
    end else if (adv) begin
      vld_q[0] <= ins_valid;
      br_q[0]  <= ins_br;
      tag_q[0] <= ins_tag;
    end
  end

  for (genvar k = 1; k < NSTG; k++) begin : g_stage
    localparam bit SQUASHABLE = (k - 1) < ST_A;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k] <= 1'b0;
        br_q[k]  <= 1'b0;
        tag_q[k] <= '0;
      end else if (adv) begin
        vld_q[k] <= vld_q[k-1] && !(SQUASHABLE && squash);
        br_q[k]  <= br_q[k-1];
        tag_q[k] <= tag_q[k-1];
      end
    end
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_out
    assign stg_tag[k*TAG_W +: TAG_W] = tag_q[k];
  end

  assign stg_valid = vld_q;
  assign a_branch  = vld_q[ST_A] && br_q[ST_A];
endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch #(
  parameter int TAG_W = 8,
  parameter int REG_W = 5,
  parameter int NSTG  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stall,
  input  logic                  br_taken,
  input  logic                  c0_valid,
  output logic                  c0_ready,
  input  logic [1:0]            c0_cls,
  input  logic                  c0_pipe,
  input  logic [REG_W-1:0]      c0_dst,
  input  logic [TAG_W-1:0]      c0_tag,
  input  logic                  c1_valid,
  output logic                  c1_ready,
  input  logic [1:0]            c1_cls,
  input  logic                  c1_pipe,
  input  logic [REG_W-1:0]      c1_dst,
  input  logic [REG_W-1:0]      c1_src_a,
  input  logic [REG_W-1:0]      c1_src_b,
  input  logic [TAG_W-1:0]      c1_tag,
  output logic [NSTG-1:0]       stg_valid_f,
  output logic [NSTG*TAG_W-1:0] stg_tag_f,
  output logic [NSTG-1:0]       stg_valid_m,
  output logic [NSTG*TAG_W-1:0] stg_tag_m,
  output logic                  redirect
);
  import dd_pkg::*;

  logic take0, take1;
  logic br_fire;
  logic adv;
  logic redirect_q;
  logic [NPIPE-1:0] a_br;
  logic [NSTG-1:0]       vld_p [NPIPE];
  logic [NSTG*TAG_W-1:0] tag_p [NPIPE];

  assign adv     = !stall;
  assign br_fire = br_taken && !stall && (|a_br);

  dd_pair_rule #(.REG_W(REG_W)) u_rule (
    .stall    (stall),
    .flush    (br_fire),
    .c0_valid (c0_valid),
    .c0_pipe  (c0_pipe),
    .c0_dst   (c0_dst),
    .c1_valid (c1_valid),
    .c1_pipe  (c1_pipe),
    .c1_dst   (c1_dst),
    .c1_src_a (c1_src_a),
    .c1_src_b (c1_src_b),
    .take0    (take0),
    .take1    (take1)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    localparam logic PID = (p == 1) ? PIPE_M : PIPE_F;
    logic             sel0, sel1;
    logic             in_v, in_br;
    logic [TAG_W-1:0] in_tag;

    always_comb begin
      sel0   = take0 && (c0_pipe == PID);
      sel1   = take1 && (c1_pipe == PID);
      in_v   = sel0 || sel1;
      in_br  = sel0 ? (c0_cls == CLS_BR) : (sel1 && (c1_cls == CLS_BR));
      in_tag = sel0 ? c0_tag : (sel1 ? c1_tag : '0);
    end

    dd_pipe_track #(.TAG_W(TAG_W), .NSTG(NSTG)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .squash    (br_fire),
      .ins_valid (in_v),
      .ins_tag   (in_tag),
      .ins_br    (in_br),
      .stg_valid (vld_p[p]),
      .stg_tag   (tag_p[p]),
      .a_branch  (a_br[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redirect_q <= 1'b0;
    else        redirect_q <= br_fire;
  end

  assign c0_ready    = take0;
  assign c1_ready    = take1;
  assign stg_valid_f = vld_p[0];
  assign stg_tag_f   = tag_p[0];
  assign stg_valid_m = vld_p[1];
  assign stg_tag_m   = tag_p[1];
  assign redirect    = redirect_q;
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
  parameter int REG_W = 5,
  parameter int NSTG  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             c0_ready,
  input logic             c0_pipe,
  input logic [REG_W-1:0] c0_dst,
  input logic             c1_ready,
  input logic             c1_pipe,
  input logic [REG_W-1:0] c1_dst,
  input logic [REG_W-1:0] c1_src_a,
  input logic [REG_W-1:0] c1_src_b,
  input logic [NSTG-1:0]  stg_valid_f,
  input logic [NSTG-1:0]  stg_valid_m,
  input logic             redirect
);
  localparam int ST_A = dd_pkg::ST_A;

  p_pipes_differ_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_ready && c1_ready) |-> (c0_pipe != c1_pipe));

  p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c1_ready |-> c0_ready);

  p_land_in_i_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_ready && c0_pipe == 1'b0) |=> stg_valid_f[0]);

  p_tail_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (stg_valid_f[NSTG-1:ST_A+1] == $past(stg_valid_f[NSTG-2:ST_A]))
            && (stg_valid_m[NSTG-1:ST_A+1] == $past(stg_valid_m[NSTG-2:ST_A])));

  p_no_hazard_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_ready && c0_dst != '0) |->
      (c1_src_a != c0_dst && c1_src_b != c0_dst && c1_dst != c0_dst));

  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!c0_ready && !c1_ready));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (stg_valid_f == $past(stg_valid_f)) && (stg_valid_m == $past(stg_valid_m)));

  p_squash_front_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (stg_valid_f[ST_A:0] == '0) && (stg_valid_m[ST_A:0] == '0));

  p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r9: assert (stg_valid_f == '0 && stg_valid_m == '0 && !redirect);
    end
  end
endmodule

bind dual_dispatch dd_checker #(.REG_W(REG_W), .NSTG(NSTG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stall       (stall),
  .c0_ready    (c0_ready),
  .c0_pipe     (c0_pipe),
  .c0_dst      (c0_dst),
  .c1_ready    (c1_ready),
  .c1_pipe     (c1_pipe),
  .c1_dst      (c1_dst),
  .c1_src_a    (c1_src_a),
  .c1_src_b    (c1_src_b),
  .stg_valid_f (stg_valid_f),
  .stg_valid_m (stg_valid_m),
  .redirect    (redirect)
);

// File: tb/sim_dual_dispatch.sv
module sim_dual_dispatch;
  localparam int TAG_W = 8;
  localparam int REG_W = 5;
  localparam int NSTG  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, br_taken = 1'b0;
  logic c0_valid = 1'b0, c1_valid = 1'b0;
  logic c0_ready, c1_ready;
  logic [1:0] c0_cls = '0, c1_cls = '0;
  logic c0_pipe = 1'b0, c1_pipe = 1'b0;
  logic [REG_W-1:0] c0_dst = '0, c1_dst = '0, c1_src_a = '0, c1_src_b = '0;
  logic [TAG_W-1:0] c0_tag = '0, c1_tag = '0;
  logic [NSTG-1:0] stg_valid_f, stg_valid_m;
  logic [NSTG*TAG_W-1:0] stg_tag_f, stg_tag_m;
  logic redirect;

  always #2 clk = ~clk;

  dual_dispatch #(.TAG_W(TAG_W), .REG_W(REG_W), .NSTG(NSTG)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // candidate slots held by the bench's fetch buffer model
  logic [1:0] q_cls [2];
  logic       q_pipe [2];
  logic [REG_W-1:0] q_dst [2], q_sa [2], q_sb [2];
  logic [TAG_W-1:0] q_tag [2];
  logic [TAG_W-1:0] seq = '0;

  // reference model of both pipes
  logic mv [2][NSTG];
  logic mb [2][NSTG];
  logic [TAG_W-1:0] mt [2][NSTG];
  logic exp_redirect = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fresh(input int s);
    q_cls[s]  = 2'($urandom_range(0, 3));
    q_pipe[s] = 1'($urandom_range(0, 1));
    q_dst[s]  = REG_W'($urandom_range(0, 6));
    q_sa[s]   = REG_W'($urandom_range(0, 6));
    q_sb[s]   = REG_W'($urandom_range(0, 6));
    q_tag[s]  = seq;
    seq++;
  endtask

  task automatic set_slot(input int s, input logic [1:0] cls, input logic pp,
                          input int d, input int a, input int b);
    q_cls[s] = cls; q_pipe[s] = pp;
    q_dst[s] = REG_W'(d); q_sa[s] = REG_W'(a); q_sb[s] = REG_W'(b);
    q_tag[s] = seq; seq++;
  endtask

  function automatic bit a_has_branch();
    return (mv[0][2] && mb[0][2]) || (mv[1][2] && mb[1][2]);
  endfunction

  function automatic string c1_reason(input bit same, input bit haz);
    if (same) return "R1";
    if (haz)  return "R4";
    return "R10";
  endfunction

  task automatic compare_stages(input string req);
    for (int k = 0; k < NSTG; k++) begin
      chk({req, " F valid"}, stg_valid_f[k], mv[0][k]);
      chk({req, " M valid"}, stg_valid_m[k], mv[1][k]);
      if (mv[0][k]) chk({req, " F tag"}, stg_tag_f[k*TAG_W +: TAG_W], mt[0][k]);
      if (mv[1][k]) chk({req, " M tag"}, stg_tag_m[k*TAG_W +: TAG_W], mt[1][k]);
    end
    chk("R7 redirect", redirect, exp_redirect);
  endtask

  // one cycle: called at a negedge, returns at the next negedge
  task automatic step(input bit st, input bit br, input bit v0, input bit v1);
    bit fire, e0, e1, same, haz;
    string req;
    stall = st; br_taken = br;
    c0_valid = v0; c1_valid = v0 && v1;
    c0_cls = q_cls[0]; c0_pipe = q_pipe[0]; c0_dst = q_dst[0]; c0_tag = q_tag[0];
    c1_cls = q_cls[1]; c1_pipe = q_pipe[1]; c1_dst = q_dst[1];
    c1_src_a = q_sa[1]; c1_src_b = q_sb[1]; c1_tag = q_tag[1];
    #1;
    fire = br && !st && a_has_branch();
    e0 = v0 && !st && !fire;
    same = (q_pipe[0] == q_pipe[1]);
    haz = (q_dst[0] != 0) &&
          (q_sa[1] == q_dst[0] || q_sb[1] == q_dst[0] || q_dst[1] == q_dst[0]);
    e1 = e0 && v1 && !same && !haz;
    req = st ? "R5" : (fire ? "R6" : ((br && !fire) ? "R8" : "R2"));
    chk({req, " c0_ready"}, c0_ready, e0);
    chk({st ? "R5" : c1_reason(same, haz), " c1_ready"}, c1_ready, e1);
    @(posedge clk);
    if (!st) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = NSTG - 1; k > 0; k--) begin
          mv[p][k] = mv[p][k-1] && !(fire && (k - 1) < 2);
          mb[p][k] = mb[p][k-1];
          mt[p][k] = mt[p][k-1];
        end
        mv[p][0] = 1'b0; mb[p][0] = 1'b0;
        if (e0 && q_pipe[0] == 1'(p)) begin
          mv[p][0] = 1'b1; mb[p][0] = (q_cls[0] == 2'd3); mt[p][0] = q_tag[0];
        end
        if (e1 && q_pipe[1] == 1'(p)) begin
          mv[p][0] = 1'b1; mb[p][0] = (q_cls[1] == 2'd3); mt[p][0] = q_tag[1];
        end
      end
    end
    exp_redirect = fire;
    if (e1) begin
      fresh(0); fresh(1);
    end else if (e0) begin
      q_cls[0] = q_cls[1]; q_pipe[0] = q_pipe[1]; q_dst[0] = q_dst[1];
      q_sa[0] = q_sa[1]; q_sb[0] = q_sb[1]; q_tag[0] = q_tag[1];
      fresh(1);
    end
    @(negedge clk);
    compare_stages(st ? "R5" : (fire ? "R6" : "R3"));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < NSTG; k++) begin
        mv[p][k] = 1'b0; mb[p][k] = 1'b0; mt[p][k] = '0;
      end
    fresh(0); fresh(1);
    repeat (3) @(negedge clk);
    chk("R9 reset F", stg_valid_f, 0);
    chk("R9 reset M", stg_valid_m, 0);
    chk("R9 reset redirect", redirect, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_stages("R9");

    // R1: two F-pipe candidates, older goes alone, younger moves up
    set_slot(0, 2'd0, 1'b0, 1, 0, 0);
    set_slot(1, 2'd2, 1'b0, 2, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    // R4: younger reads older's destination
    set_slot(0, 2'd1, 1'b1, 5, 0, 0);
    set_slot(1, 2'd0, 1'b0, 6, 3, 5);
    step(0, 0, 1, 1);
    // R4: same destination
    set_slot(0, 2'd1, 1'b1, 4, 0, 0);
    set_slot(1, 2'd0, 1'b0, 4, 1, 2);
    step(0, 0, 1, 1);
    // R10: destination 0 does not block
    set_slot(0, 2'd0, 1'b0, 0, 0, 0);
    set_slot(1, 2'd2, 1'b1, 0, 0, 0);
    step(0, 0, 1, 1);
    // R8: br_taken with no branch in A
    step(0, 1, 1, 1);
    // R5: stall for a few cycles
    step(1, 0, 1, 1);
    step(1, 1, 1, 1);
    // R6/R7: put a branch into A and take it
    set_slot(0, 2'd3, 1'b0, 0, 0, 0);
    set_slot(1, 2'd0, 1'b1, 7, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    step(0, 1, 1, 1);
    step(0, 0, 1, 1);

    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 9) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 9) != 0, $urandom_range(0, 7) != 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule